// File: doc/BRIEF.md
# Serial Converter Readout Frame Controller

This block is the digital serial side of a multichannel sampling converter. It acts as a slave on a three-wire bus made of an active-low chip select, a serial clock and a data output, plus a serial command input. Each chip-select window carries one 16-bit frame. The frame gives the channel address of the result first and then the converted sample, with the most significant bit first in both parts. The analog converter is replaced by a parallel `sample` input, which is captured when chip select falls.

A command word shifts in on the serial input during the same frame. When its write flag is set, it loads the control state: a power mode, a bus-release style, a sequence enable and a channel address. Between frames the data line is either released completely or weakly held at the top address bit of the next frame, so a master can sample that bit on its first clock edge. In the two automatic low-power modes the converter sleeps after each conversion. The next complete frame is then spent as a wake-up dummy in which the line is never driven strongly, and the frame after it converts again.

All bus inputs are sampled by the system clock `clk`. The outputs change on the `clk` edge that sees the bus event.

Top module: `adcrd_frame`

## Requirements
- R1: A converting frame presents 16 bits: the 4-bit channel address (MSB first), then the 12-bit `sample` value captured at the chip-select falling edge (MSB first).
- R2: Bit 15 appears with strong drive on the `clk` edge that sees chip select fall. Each later bit appears on the `clk` edge that sees a falling edge of `sclk`. The value does not change between these events.
- R3: The falling `sclk` edge that completes 16 edges ends strong drive even if chip select stays low. Further falling edges in the same window are ignored.
- R4: While chip select is high, strong drive is off. A window closed before 16 falling edges leaves the channel, the power state and the control settings unchanged.
- R5: With the release bit at 0, whenever strong drive is off `dout_weak` is 0 and `dout` is 0.
- R6: With the release bit at 1, whenever strong drive is off `dout_weak` is 1 and `dout` equals bit 3 of the channel that the next frame will carry. `dout_oe` and `dout_weak` are never 1 together.
- R7: The command word is sampled from `din` on the 16 falling `sclk` edges, MSB first: bit 15 write flag, bits 14:13 power mode, bit 12 release bit, bit 11 sequence enable, bits 10:7 channel address, bits 6:0 ignored. It takes effect at the 16th edge only when bit 15 is 1.
- R8: A write loads the channel from bits 10:7. Without a write, a converting frame advances the channel by one (wrapping from 15 to 0) when sequence is enabled, and leaves it unchanged when sequence is disabled.
- R9: Power mode 01 (auto shutdown) and 00 (auto standby) put the block to sleep after each converting frame. The next complete frame is a dummy with no strong drive and no channel step, and the frame after it converts. Modes 1x never sleep. The power mode used is the one in force after any write in the same frame.
- R10: After reset the block is awake on channel 0 with power mode 11, release bit 0 and sequence off. `dout`, `dout_oe` and `dout_weak` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; idles high |
| din | input | 1 | Serial command input |
| sample | input | 12 | Stand-in for the converter result |
| dout | output | 1 | Serial data level |
| dout_oe | output | 1 | Strong drive enable for `dout` |
| dout_weak | output | 1 | Weak hold of `dout` between frames |

## Verification
The checker assumes that `cs_n` and `sclk` are synchronous to `clk` and that each level is held for at least two `clk` cycles. Under that assumption, every bus edge appears as one single-cycle event in the design and in the checker's own edge tracking. The bench changes every bus input on falling `clk` edges and holds each `sclk` phase for two cycles. It waits three cycles after each chip-select change, so no edge is ever shorter than the assumed minimum.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        PWR_AWAKE    = 2'd0,
        PWR_STANDBY  = 2'd1,
        PWR_SHUTDOWN = 2'd2
    } pwr_e;

    // Command fields below the write flag, most significant first.
    typedef struct packed {
        logic [1:0]        pm;
        logic              weak_en;
        logic              seq_en;
        logic [ADDR_W-1:0] addr;
    } ctrl_word_t;

    localparam int CMD_W = 1 + $bits(ctrl_word_t);

    localparam logic [1:0] PM_STANDBY  = 2'b00;
    localparam logic [1:0] PM_SHUTDOWN = 2'b01;
    localparam logic [1:0] PM_NORMAL   = 2'b11;

    // State entered after a conversion under a given power mode.
    function automatic pwr_e rest_state(input logic [1:0] pm);
        case (pm)
            PM_STANDBY:  return PWR_STANDBY;
            PM_SHUTDOWN: return PWR_SHUTDOWN;
            default:     return PWR_AWAKE;
        endcase
    endfunction

endpackage

// File: rtl/adcrd_edge.sv
module adcrd_edge (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sclk,
    output logic cs_fall,
    output logic sclk_fall
);
    logic cs_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign cs_fall   = cs_q & ~cs_n;
    assign sclk_fall = sclk_q & ~sclk;
endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift
    import adcrd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs_fall,
    input  logic              sclk_fall,
    input  logic              din,
    input  logic              live,
    input  logic [ADDR_W-1:0] chan,
    input  logic [DATA_W-1:0] sample,
    output logic              frame_done,
    output logic [CMD_W-1:0]  cmd,
    output logic              tx_oe,
    output logic              tx_bit
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] tx;
    logic [FRAME_W-2:0] rx;
    logic [FRAME_W-1:0] rx_next;
    logic               step;

    // A fall is counted only inside an open window that is not yet full.
    assign step       = sclk_fall & ~cs_n & ~cs_fall & (cnt != CNT_END);
    assign rx_next    = {rx, din};
    assign frame_done = step & (cnt == CNT_LAST);
    assign cmd        = rx_next[FRAME_W-1 -: CMD_W];
    assign tx_bit     = tx[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= CNT_END;
            tx    <= '0;
            rx    <= '0;
            tx_oe <= 1'b0;
        end else if (cs_n) begin
            cnt   <= CNT_END;
            tx_oe <= 1'b0;
        end else if (cs_fall) begin
            cnt   <= '0;
            tx    <= {chan, sample};
            rx    <= '0;
            tx_oe <= live;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            tx  <= {tx[FRAME_W-2:0], 1'b0};
            rx  <= rx_next[FRAME_W-2:0];
            if (cnt == CNT_LAST) begin
                tx_oe <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
    import adcrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    input  logic [CMD_W-1:0]  cmd,
    output logic              weak_en,
    output logic [ADDR_W-1:0] chan,
    output logic              awake
);
    logic       wr;
    ctrl_word_t word;
    logic [1:0] pm_q;
    logic [1:0] pm_eff;
    logic       seq_q;
    pwr_e       pwr_q;

    always_comb begin
        wr     = cmd[CMD_W-1];
        word   = ctrl_word_t'(cmd[CMD_W-2:0]);
        pm_eff = wr ? word.pm : pm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q    <= PM_NORMAL;
            weak_en <= 1'b0;
            seq_q   <= 1'b0;
            chan    <= '0;
            pwr_q   <= PWR_AWAKE;
        end else if (frame_done) begin
            if (wr) begin
                pm_q    <= word.pm;
                weak_en <= word.weak_en;
                seq_q   <= word.seq_en;
                chan    <= word.addr;
            end else if (pwr_q == PWR_AWAKE && seq_q) begin
                chan <= chan + 1'b1;
            end
            if (pwr_q == PWR_AWAKE) begin
                pwr_q <= rest_state(pm_eff);
            end else begin
                pwr_q <= PWR_AWAKE;
            end
        end
    end

    assign awake = (pwr_q == PWR_AWAKE);
endmodule

// File: rtl/adcrd_frame.sv
module adcrd_frame
    import adcrd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic [DATA_W-1:0] sample,
    output logic              dout,
    output logic              dout_oe,
    output logic              dout_weak
);
    logic              cs_fall;
    logic              sclk_fall;
    logic              frame_done;
    logic [CMD_W-1:0]  cmd;
    logic              tx_oe;
    logic              tx_bit;
    logic              weak_en;
    logic [ADDR_W-1:0] chan;
    logic              awake;

    adcrd_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .cs_fall   (cs_fall),
        .sclk_fall (sclk_fall)
    );

    adcrd_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .cs_fall    (cs_fall),
        .sclk_fall  (sclk_fall),
        .din        (din),
        .live       (awake),
        .chan       (chan),
        .sample     (sample),
        .frame_done (frame_done),
        .cmd        (cmd),
        .tx_oe      (tx_oe),
        .tx_bit     (tx_bit)
    );

    adcrd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .cmd        (cmd),
        .weak_en    (weak_en),
        .chan       (chan),
        .awake      (awake)
    );

    always_comb begin
        dout_oe   = tx_oe;
        dout_weak = ~tx_oe & weak_en;
        if (tx_oe) begin
            dout = tx_bit;
        end else begin
            dout = weak_en & chan[ADDR_W-1];
        end
    end
endmodule

// File: rtl/adcrd_frame_chk.sv
module adcrd_frame_chk
    import adcrd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic dout,
    input logic dout_oe,
    input logic dout_weak
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] FALL_END = CNT_W'(FRAME_W);

    logic             cs_d;
    logic             sclk_d;
    logic [CNT_W-1:0] falls;

    // Own count of serial-clock falls inside the current window.
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b1;
            falls  <= FALL_END;
        end else begin
            cs_d   <= cs_n;
            sclk_d <= sclk;
            if (cs_n) begin
                falls <= FALL_END;
            end else if (cs_d) begin
                falls <= '0;
            end else if (sclk_d && !sclk && falls != FALL_END) begin
                falls <= falls + 1'b1;
            end
        end
    end

    a_r6_drive_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dout_oe && dout_weak));

    a_r4_idle_no_strong: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> !dout_oe);

    a_r3_release_after_frame: assert property (@(posedge clk) disable iff (rst)
        (falls == FALL_END) |-> !dout_oe);

    a_r2_strong_starts_at_select: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> (!$past(cs_n) && $past(cs_n, 2)));

    a_r2_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
        (dout_oe && $past(dout_oe) && !($past(sclk, 2) && !$past(sclk)))
            |-> $stable(dout));
endmodule

bind adcrd_frame adcrd_frame_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .dout_weak (dout_weak)
);

// File: tb/adcrd_frame_test.sv
module adcrd_frame_test;
    localparam int DW = 12;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b1;
    logic          din = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          dout;
    logic          dout_oe;
    logic          dout_weak;

    adcrd_frame #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .sample    (sample),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .dout_weak (dout_weak)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [FW-1:0] got;
    int            oe_cnt;
    int            extra_oe;
    logic          post_oe, post_weak, post_dout;
    logic          idle_oe, idle_weak, idle_dout;

    // Expected state, kept from the requirements.
    logic [3:0] m_chan  = 4'd0;
    logic [1:0] m_pm    = 2'b11;
    logic       m_wt    = 1'b0;
    logic       m_seq   = 1'b0;
    logic       m_sleep = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] cw(input bit wr, input logic [1:0] pm, input bit wt,
                                         input bit seq, input logic [3:0] a);
        return {wr, pm, wt, seq, a, 7'b0};
    endfunction

    task automatic shift_frame(input logic [FW-1:0] ctl, input int nfall);
        got = '0; oe_cnt = 0; extra_oe = 0;
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < nfall; i++) begin
            din = (i < FW) ? ctl[FW-1-i] : 1'b0;
            repeat (2) @(negedge clk);
            if (i < FW) begin
                got[FW-1-i] = dout;
                if (dout_oe) oe_cnt++;
            end else if (dout_oe) begin
                extra_oe++;
            end
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
        end
        repeat (2) @(negedge clk);
        post_oe = dout_oe; post_weak = dout_weak; post_dout = dout;
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        idle_oe = dout_oe; idle_weak = dout_weak; idle_dout = dout;
    endtask

    task automatic model(input logic [FW-1:0] ctl);
        logic [1:0] pm_eff;
        pm_eff = ctl[15] ? ctl[14:13] : m_pm;
        if (ctl[15]) begin
            m_pm = ctl[14:13]; m_wt = ctl[12]; m_seq = ctl[11]; m_chan = ctl[10:7];
        end else if (!m_sleep && m_seq) begin
            m_chan = m_chan + 4'd1;
        end
        if (!m_sleep) m_sleep = (pm_eff == 2'b00) || (pm_eff == 2'b01);
        else          m_sleep = 1'b0;
    endtask

    task automatic full_frame(input logic [FW-1:0] ctl, input logic [DW-1:0] smp, input int nfall);
        logic       was_sleep;
        logic [3:0] ch;
        was_sleep = m_sleep;
        ch = m_chan;
        sample = smp;
        shift_frame(ctl, nfall);
        if (!was_sleep) begin
            check("R1 R8", "frame word", int'(got), int'({ch, smp}));
            check("R2", "strongly driven bits", oe_cnt, FW);
        end else begin
            check("R9", "strong bits in dummy frame", oe_cnt, 0);
        end
        check("R3", "strong drive after 16th edge", int'(post_oe), 0);
        if (nfall > FW) check("R3", "strong drive on extra edges", extra_oe, 0);
        model(ctl);
        check("R4", "strong drive with select high", int'(idle_oe), 0);
        check(m_wt ? "R6" : "R5", "weak flag idle", int'(idle_weak), int'(m_wt));
        check(m_wt ? "R6" : "R5", "line level idle", int'(idle_dout), m_wt ? int'(m_chan[3]) : 0);
        check(m_wt ? "R6" : "R5", "weak flag after 16th edge", int'(post_weak), int'(m_wt));
        check(m_wt ? "R6" : "R5", "line level after 16th edge", int'(post_dout),
              m_wt ? int'(m_chan[3]) : 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "dout_oe after reset", int'(dout_oe), 0);
        check("R10", "dout_weak after reset", int'(dout_weak), 0);
        check("R10", "dout after reset", int'(dout), 0);

        full_frame('0, 12'hA5C, FW);
        full_frame(cw(1, 2'b11, 0, 1, 4'd3), 12'h123, FW);
        // R8 sweep through and past the channel wrap
        for (int i = 0; i < 20; i++) full_frame('0, DW'((i * 12'h1F3 + 7) & 12'hFFF), FW);
        full_frame('0, 12'h0F0, FW + 2);

        // R4: a closed-early window carrying a write changes nothing
        sample = 12'h555;
        shift_frame(cw(1, 2'b01, 1, 0, 4'd9), 5);
        check("R4", "strong drive after early close", int'(idle_oe), 0);
        full_frame('0, 12'hFFF, FW);

        full_frame(cw(1, 2'b11, 1, 1, 4'd6), 12'h321, FW);
        check("R7", "release bit loaded", int'(idle_weak), 1);
        for (int i = 0; i < 3; i++) full_frame('0, DW'(12'h800 + i), FW);
        full_frame(cw(1, 2'b11, 0, 1, 4'd14), 12'h456, FW);

        // R9 auto shutdown: convert, dummy, convert ...
        full_frame(cw(1, 2'b01, 0, 1, 4'd2), 12'h789, FW);
        for (int i = 0; i < 4; i++) full_frame('0, DW'(12'h3C0 + i), FW);
        // R9 auto standby, written during a dummy frame
        full_frame(cw(1, 2'b00, 0, 1, 4'd12), 12'h111, FW);
        for (int i = 0; i < 3; i++) full_frame('0, DW'(12'hC30 + i), FW);
        // R9 mode 10 never sleeps
        full_frame(cw(1, 2'b10, 0, 1, 4'd0), 12'h222, FW);
        for (int i = 0; i < 3; i++) full_frame('0, DW'(12'h0A0 + i), FW);

        // R8 sequence off holds the channel
        full_frame(cw(1, 2'b11, 0, 0, 4'd5), 12'h9AB, FW);
        full_frame('0, 12'h9AC, FW);
        full_frame('0, 12'h9AD, FW);

        // R7 fields without the write flag are ignored
        full_frame(cw(0, 2'b01, 1, 1, 4'd15), 12'h777, FW);
        check("R7", "weak flag after unwritten word", int'(idle_weak), 0);
        full_frame('0, 12'h778, FW);
        full_frame('0, 12'h779, FW);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule